// File: doc/BRIEF.md
# Supply Voltage Detector Control Register

This block is a single byte-wide register on a CPU bus that controls an external supply voltage comparator. Software turns the detector on and picks one of three trip levels (1.9 V, 2.8 V, 3.4 V). The block drives an enable and a decoded level code to the analog comparator. The comparator's output comes back as an asynchronous digital input.

Software reads the result only after it turns the detector off. On the write that clears the enable, the synchronised comparator output is frozen into a read-only result bit. That bit then holds until the next time the enable is cleared.

A side-band flag reports whether the detector has been on long enough to give a trustworthy reading. The minimum on-time is 100 µs, counted in clock cycles.

Top module: `supply_mon_reg`

## Requirements
- R1: After reset the register reads 0x00, the detector enable and the settled flag are 0, and the level code is 0.
- R2: A bus write to the register address stores bit 0 as the detector enable and bits 3:2 as the level select. det_en_o shows the new enable one cycle after the write. Both fields read back in the same bit positions.
- R3: Register bits 7:4 always read 0, even after a write of ones to them.
- R4: Bit 1 is the result and is read-only. A write to it leaves its value unchanged.
- R5: The level code is 2 (3.4 V) when select bit 3 is 1, whatever bit 2 holds. It is 1 (2.8 V) when bits 3:2 are 01, and 0 (1.9 V) when they are 00.
- R6: On the clock edge where the enable goes from 1 to 0, the result bit takes the comparator input. The comparator input must have been steady for at least two cycles before that edge. A 1 means the supply is below the level and a 0 means it is at or above. Comparator changes at any other time do not alter the result.
- R7: settled_o rises exactly 12 500 cycles (100 µs at 125 MHz) after the write that sets the enable. It falls in the same cycle that the enable falls.
- R8: Writes to any other address change nothing. Reads from any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Bus address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data, 0 when the address does not match |
| cmp_low_i | input | 1 | Asynchronous comparator output, 1 = supply below level |
| det_en_o | output | 1 | Detector enable to the analog block |
| lvl_code_o | output | 2 | Decoded trip level: 0 = 1.9 V, 1 = 2.8 V, 2 = 3.4 V |
| settled_o | output | 1 | Minimum on-time has elapsed |

## Verification
An enable flop that is wrong shows up on det_en_o and in register bit 0 one cycle after the write. A select flop that is wrong shows up on lvl_code_o in that same cycle.

A result flop that captures at the wrong moment, or captures the wrong stage of the synchroniser, only becomes visible after the next disable. The bench therefore changes the comparator before the disable, holds it for the two-cycle window, and changes it again afterwards.

A settle counter that is off by one shows as settled_o rising one cycle early or late. The bench samples the cycle before the expected rise and the cycle of the expected rise.

// File: rtl/supply_mon_reg.sv
module supply_mon_reg #(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REG_ADDR  = 8'h56,
  parameter int          CLK_HZ    = 125_000_000,
  parameter int          SETTLE_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cmp_low_i,
  output logic              det_en_o,
  output logic [1:0]        lvl_code_o,
  output logic              settled_o
);
  localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int CW         = $clog2(SETTLE_CYC + 1);

  logic          hit, wr_hit;
  logic          en_q, res_q, sy1, sy2;
  logic [1:0]    sel_q;
  logic [CW-1:0] cnt_q;
  logic          unused_wdata;

  assign hit    = (bus_addr == REG_ADDR[ADDR_W-1:0]);
  assign wr_hit = hit && bus_wr;
  assign unused_wdata = &{1'b0, bus_wdata[7:4], bus_wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 2'b00;
    end else if (wr_hit) begin
      en_q  <= bus_wdata[0];
      sel_q <= bus_wdata[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b0;
      sy2 <= 1'b0;
    end else begin
      sy1 <= cmp_low_i;
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             res_q <= 1'b0;
    else if (wr_hit && en_q && !bus_wdata[0]) res_q <= sy2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt_q <= '0;
    else if (!en_q)                          cnt_q <= '0;
    else if (cnt_q != CW'(SETTLE_CYC))       cnt_q <= cnt_q + 1'b1;
  end

  assign det_en_o   = en_q;
  assign settled_o  = en_q && (cnt_q == CW'(SETTLE_CYC));
  assign lvl_code_o = sel_q[1] ? 2'd2 : (sel_q[0] ? 2'd1 : 2'd0);
  assign bus_rdata  = hit ? {4'b0000, sel_q, res_q, en_q} : 8'h00;
endmodule

// File: rtl/supply_mon_chk.sv
module supply_mon_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              det_en_o,
  input logic [1:0]        lvl_code_o,
  input logic              settled_o,
  input logic [1:0]        sel_q,
  input logic              res_q,
  input logic              sy2
);
  assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_wr) |=> (det_en_o == $past(bus_wdata[0])));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:4] == 4'b0000);

  assert_top_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[1] |-> (lvl_code_o == 2'd2));

  assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_en_o) |-> (res_q == $past(sy2)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(det_en_o) |-> $stable(res_q));

  assert_settled_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    settled_o |-> det_en_o);

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (bus_rdata == 8'h00));
endmodule

bind supply_mon_reg supply_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .det_en_o(det_en_o), .lvl_code_o(lvl_code_o),
  .settled_o(settled_o), .sel_q(sel_q), .res_q(res_q), .sy2(sy2)
);

// File: tb/tb_supply_mon_reg.sv
`timescale 1ns/1ps
module tb_supply_mon_reg;
  localparam logic [7:0] A    = 8'h56;
  localparam int         NSET = 12500;

  logic       clk = 0, rst_n = 0, bus_wr = 0, cmp = 0;
  logic [7:0] addr = A, wdata = 0, rdata;
  logic       en, settled;
  logic [1:0] lvl;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  supply_mon_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(bus_wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .cmp_low_i(cmp),
    .det_en_o(en), .lvl_code_o(lvl), .settled_o(settled)
  );

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; addr = A;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = A;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(A, d);
    chk("R1", "reg", d, 8'h00);
    chk("R1", "en", en, 0);
    chk("R1", "lvl", lvl, 0);
    chk("R1", "settled", settled, 0);
  endtask

  task automatic t_rw;
    logic [7:0] d;
    wr(A, 8'h05);
    chk("R2", "det_en_o", en, 1);
    rd(A, d); chk("R2", "readback", d, 8'h05);
    wr(A, 8'h08);
    rd(A, d); chk("R2", "readback2", d, 8'h08);
    chk("R2", "det_en_o off", en, 0);
  endtask

  task automatic t_unused;
    logic [7:0] d;
    wr(A, 8'hF4);
    rd(A, d); chk("R3", "upper bits", d, 8'h04);
  endtask

  task automatic t_thresh;
    wr(A, 8'h00); chk("R5", "sel00", lvl, 0);
    wr(A, 8'h04); chk("R5", "sel01", lvl, 1);
    wr(A, 8'h08); chk("R5", "sel10", lvl, 2);
    wr(A, 8'h0C); chk("R5", "sel11", lvl, 2);
  endtask

  task automatic t_capture;
    logic [7:0] d;
    wr(A, 8'h01); cmp = 1;
    repeat (3) @(negedge clk);
    wr(A, 8'h00);
    rd(A, d); chk("R6", "capture low", d[1], 1);
    cmp = 0; repeat (4) @(negedge clk);
    rd(A, d); chk("R6", "hold after cmp change", d[1], 1);
    wr(A, 8'h00);
    rd(A, d); chk("R6", "no capture while off", d[1], 1);
    wr(A, 8'h01); repeat (3) @(negedge clk);
    wr(A, 8'h00); cmp = 1;
    rd(A, d); chk("R6", "capture normal", d[1], 0);
    cmp = 0;
  endtask

  task automatic t_ro;
    logic [7:0] d;
    wr(A, 8'h01); cmp = 1; repeat (3) @(negedge clk);
    wr(A, 8'h00); cmp = 0;
    wr(A, 8'h00);
    rd(A, d); chk("R4", "write 0 to result", d[1], 1);
    wr(A, 8'h01); repeat (3) @(negedge clk);
    wr(A, 8'h00);
    wr(A, 8'h02);
    rd(A, d); chk("R4", "write 1 to result", d[1], 0);
  endtask

  task automatic t_settle;
    wr(A, 8'h01);
    repeat (NSET - 1) @(posedge clk);
    @(negedge clk); chk("R7", "before limit", settled, 0);
    @(negedge clk); chk("R7", "at limit", settled, 1);
    repeat (5) @(negedge clk); chk("R7", "saturated", settled, 1);
    wr(A, 8'h00); chk("R7", "cleared", settled, 0);
    wr(A, 8'h01); repeat (10) @(negedge clk);
    chk("R7", "restart from zero", settled, 0);
    wr(A, 8'h00);
  endtask

  task automatic t_addr;
    logic [7:0] d;
    wr(A, 8'h09);
    wr(8'h57, 8'h04);
    rd(A, d); chk("R8", "other addr write", d, 8'h09);
    rd(8'h55, d); chk("R8", "other addr read", d, 8'h00);
    wr(A, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_rw; t_unused; t_thresh; t_capture; t_ro; t_settle; t_addr;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule